// File: doc/BRIEF.md
# Toroidal 8x8 Neighbour Shift Unit

This block rearranges a 64-element data vector that is treated as a square grid of 8 rows by 8 columns. On a start strobe, each destination element takes the value of one neighbouring source element. The neighbour lies one step away in one of eight compass directions, chosen by a 3-bit direction code. Both axes wrap around, so the grid behaves as a torus. This lets each grid cell interact with its nearest neighbours in a two-dimensional stencil computation.

A per-element enable mask selects which destination elements are rewritten. A masked-off element keeps the value of the old destination vector that is presented alongside the source. The element width is a parameter; decoding the operation and storing the vectors belong to the surrounding datapath. The new vector is registered and appears one clock after the strobe, together with a one-cycle completion pulse.

Top module: `torus_shift_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no start strobe, `dst_new` is all zeros and `done` is 0.
- R2: `done` is 1 in exactly the cycle after a cycle in which `start` was 1, and 0 in every other cycle.
- R3: Element k sits at row k/8 and column k%8, with row 0 holding elements 0..7 and row 7 holding 56..63. Destination element (row r, column c) is loaded from source element ((r+dy) mod 8)*8 + ((c+dx) mod 8). The direction code gives (dx,dy) as: 000=(-1,-1), 001=(0,-1), 010=(+1,-1), 011=(-1,0), 100=(+1,0), 101=(-1,+1), 110=(0,+1), 111=(+1,+1).
- R4: With code 100 (dx=+1), destination element 18 holds source element 19.
- R5: With code 110 (dy=+1), destination element 18 holds source element 26.
- R6: Columns wrap: with dx=+1, column 7 of a row reads column 0 of the same row, and with dx=-1, column 0 reads column 7.
- R7: Rows wrap: with dy=+1, row 7 reads row 0, and with dy=-1, row 0 reads row 7.
- R8: Where mask bit k is 0 at the start strobe, element k of `dst_new` equals element k of `dst_old` sampled in that same cycle. Where mask bit k is 1, element k takes the neighbour value.
- R9: In a cycle without `start`, `dst_new` keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that samples the inputs |
| dir_code | input | 3 | Neighbour direction code (see R3) |
| mask | input | 64 | Per-element write enable, bit k for element k |
| src_vec | input | 64*ELEM_W | Source vector, element k at bits [k*ELEM_W +: ELEM_W] |
| dst_old | input | 64*ELEM_W | Previous destination vector, same layout |
| dst_new | output | 64*ELEM_W | Registered result vector |
| done | output | 1 | Pulses high for one cycle when `dst_new` is updated |

## Verification
Both the new vector and the completion pulse are due one rising edge after the strobe: the inputs are sampled at that edge and the output register updates at the same edge. The bench drives inputs at a falling edge, raises `start` for exactly one clock, and reads `dst_new` and `done` at the next falling edge, which falls in the first cycle after the update. It then checks that `done` has dropped one cycle later and that `dst_new` holds while inputs change without a strobe.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

  localparam int CODE_W = 3;
  localparam int NUM_DIRS = 1 << CODE_W;

  // Column step of a direction code: -1, 0 or +1.
  function automatic int dir_dx(input logic [CODE_W-1:0] code);
    case (code)
      3'b000, 3'b011, 3'b101: return -1;
      3'b001, 3'b110:         return 0;
      default:                return 1;
    endcase
  endfunction

  // Row step of a direction code: -1, 0 or +1 (rows grow upward).
  function automatic int dir_dy(input logic [CODE_W-1:0] code);
    case (code)
      3'b000, 3'b001, 3'b010: return -1;
      3'b011, 3'b100:         return 0;
      default:                return 1;
    endcase
  endfunction

  // Source element index feeding destination element elem on a torus of side x side.
  function automatic int nb_index(input int elem, input logic [CODE_W-1:0] code, input int side);
    int row;
    int col;
    row = elem / side;
    col = elem % side;
    row = (row + dir_dy(code) + side) % side;
    col = (col + dir_dx(code) + side) % side;
    return row * side + col;
  endfunction

endpackage

// File: rtl/tsu_dir_decode.sv
module tsu_dir_decode
  import tsu_pkg::*;
(
  input  logic [CODE_W-1:0]   code,
  output logic [NUM_DIRS-1:0] sel
);
  // One-hot select per direction.
  for (genvar k = 0; k < NUM_DIRS; k++) begin : g_sel
    assign sel[k] = (code == CODE_W'(k));
  end
endmodule

// File: rtl/tsu_neighbour_gather.sv
module tsu_neighbour_gather
  import tsu_pkg::*;
#(
  parameter int SIDE   = 8,
  parameter int ELEM_W = 8,
  localparam int NELEM = SIDE * SIDE,
  localparam int VEC_W = NELEM * ELEM_W
) (
  input  logic [VEC_W-1:0]    src_vec,
  input  logic [NUM_DIRS-1:0] sel,
  output logic [VEC_W-1:0]    gathered
);
  for (genvar e = 0; e < NELEM; e++) begin : g_elem
    logic [ELEM_W-1:0] cand [NUM_DIRS];
    logic [ELEM_W-1:0] pick;

    // Each destination has a fixed set of eight wired candidates.
    for (genvar k = 0; k < NUM_DIRS; k++) begin : g_cand
      localparam int SRC = nb_index(e, CODE_W'(k), SIDE);
      assign cand[k] = src_vec[SRC*ELEM_W +: ELEM_W] & {ELEM_W{sel[k]}};
    end

    always_comb begin
      pick = '0;
      for (int k = 0; k < NUM_DIRS; k++) pick = pick | cand[k];
    end

    assign gathered[e*ELEM_W +: ELEM_W] = pick;
  end
endmodule

// File: rtl/tsu_merge_reg.sv
module tsu_merge_reg #(
  parameter int NELEM  = 64,
  parameter int ELEM_W = 8,
  localparam int VEC_W = NELEM * ELEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [NELEM-1:0] mask,
  input  logic [VEC_W-1:0] gathered,
  input  logic [VEC_W-1:0] dst_old,
  output logic [VEC_W-1:0] dst_q,
  output logic             done_q
);
  logic [VEC_W-1:0] merged;

  for (genvar e = 0; e < NELEM; e++) begin : g_merge
    assign merged[e*ELEM_W +: ELEM_W] = mask[e] ? gathered[e*ELEM_W +: ELEM_W]
                                                : dst_old[e*ELEM_W +: ELEM_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= load_en;
      if (load_en) dst_q <= merged;
    end
  end
endmodule

// File: rtl/torus_shift_unit.sv
module torus_shift_unit
  import tsu_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int SIDE   = 8,
  localparam int NELEM = SIDE * SIDE,
  localparam int VEC_W = NELEM * ELEM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] dir_code,
  input  logic [NELEM-1:0]  mask,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [VEC_W-1:0]  dst_old,
  output logic [VEC_W-1:0]  dst_new,
  output logic              done
);
  // Named internal events for the checker.
  logic [NUM_DIRS-1:0] dir_sel;
  logic [VEC_W-1:0]    gathered;
  logic                load_en;

  assign load_en = start;

  tsu_dir_decode u_dec (
    .code (dir_code),
    .sel  (dir_sel)
  );

  tsu_neighbour_gather #(.SIDE(SIDE), .ELEM_W(ELEM_W)) u_gather (
    .src_vec  (src_vec),
    .sel      (dir_sel),
    .gathered (gathered)
  );

  tsu_merge_reg #(.NELEM(NELEM), .ELEM_W(ELEM_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .mask     (mask),
    .gathered (gathered),
    .dst_old  (dst_old),
    .dst_q    (dst_new),
    .done_q   (done)
  );
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker
  import tsu_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int SIDE   = 8,
  localparam int NELEM = SIDE * SIDE,
  localparam int VEC_W = NELEM * ELEM_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [CODE_W-1:0]   dir_code,
  input logic [NELEM-1:0]    mask,
  input logic [VEC_W-1:0]    src_vec,
  input logic [VEC_W-1:0]    dst_old,
  input logic [VEC_W-1:0]    dst_new,
  input logic                done,
  input logic [NUM_DIRS-1:0] dir_sel
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(dst_new)); // R9
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dir_sel) && (dir_sel != '0)); // R3

  for (genvar e = 0; e < NELEM; e++) begin : g_elem
    localparam int EAST = nb_index(e, 3'b100, SIDE);
    AST_MASKED_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !mask[e]) |=> dst_new[e*ELEM_W +: ELEM_W] == $past(dst_old[e*ELEM_W +: ELEM_W])); // R8
    AST_EAST_WRAP_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mask[e] && dir_code == 3'b100)
        |=> dst_new[e*ELEM_W +: ELEM_W] == $past(src_vec[EAST*ELEM_W +: ELEM_W])); // R6
  end
endmodule

bind torus_shift_unit tsu_checker #(.ELEM_W(ELEM_W), .SIDE(SIDE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .dir_code (dir_code),
  .mask     (mask),
  .src_vec  (src_vec),
  .dst_old  (dst_old),
  .dst_new  (dst_new),
  .done     (done),
  .dir_sel  (dir_sel)
);

// File: tb/torus_shift_unit_test.sv
`timescale 1ns/1ps
module torus_shift_unit_test;
  localparam int W = 8;
  localparam int N = 64;
  localparam int VW = N * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    dir_code = '0;
  logic [N-1:0]  mask = '0;
  logic [VW-1:0] src_vec = '0;
  logic [VW-1:0] dst_old = '0;
  logic [VW-1:0] dst_new;
  logic          done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  torus_shift_unit #(.ELEM_W(W), .SIDE(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_code(dir_code), .mask(mask),
    .src_vec(src_vec), .dst_old(dst_old), .dst_new(dst_new), .done(done)
  );

  // {code, destination element, expected source element}
  typedef struct packed { logic [2:0] code; logic [5:0] dst; logic [5:0] src; } vec_t;
  localparam vec_t TABLE [14] = '{
    '{3'b100, 6'd18, 6'd19},  // R4
    '{3'b110, 6'd18, 6'd26},  // R5
    '{3'b100, 6'd23, 6'd16},  // R6 east wrap
    '{3'b011, 6'd16, 6'd23},  // R6 west wrap
    '{3'b110, 6'd60, 6'd4},   // R7 up wrap
    '{3'b001, 6'd4,  6'd60},  // R7 down wrap
    '{3'b111, 6'd63, 6'd0},   // R7 corner
    '{3'b000, 6'd0,  6'd63},  // R6 corner
    '{3'b010, 6'd18, 6'd11},  // R3
    '{3'b101, 6'd18, 6'd25},  // R3
    '{3'b011, 6'd18, 6'd17},  // R3
    '{3'b001, 6'd18, 6'd10},  // R3
    '{3'b000, 6'd18, 6'd9},   // R3
    '{3'b111, 6'd18, 6'd27}   // R3
  };

  function automatic logic [W-1:0] src_val(int i);
    return W'(i * 3 + 7);
  endfunction

  function automatic logic [W-1:0] old_val(int i);
    return W'(8'hC0 ^ i);
  endfunction

  // Independent model of R3: offsets listed by code.
  function automatic int model_src(int d, logic [2:0] code);
    int ox [8] = '{7, 0, 1, 7, 1, 7, 0, 1};
    int oy [8] = '{7, 7, 7, 0, 0, 1, 1, 1};
    return (((d >> 3) + oy[code]) & 7) * 8 + (((d & 7) + ox[code]) & 7);
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] code, input logic [N-1:0] m);
    @(negedge clk);
    dir_code = code; mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [W-1:0] el(logic [VW-1:0] v, int i);
    return v[i*W +: W];
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] held;
    for (int i = 0; i < N; i++) begin
      src_vec[i*W +: W] = src_val(i);
      dst_old[i*W +: W] = old_val(i);
    end
    repeat (3) @(negedge clk);
    check(dst_new == '0, "R1 reset dst", el(dst_new, 0), 0);
    check(done == 1'b0, "R1 reset done", W'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dst_new == '0 && !done, "R1 after release", el(dst_new, 0), 0);

    // Table walk: full mask.
    foreach (TABLE[t]) begin
      pulse(TABLE[t].code, '1);
      check(done == 1'b1, "R2 done due", W'(done), 1);
      check(el(dst_new, TABLE[t].dst) == src_val(TABLE[t].src), "R3/R4/R5/R6/R7 table",
            el(dst_new, TABLE[t].dst), src_val(TABLE[t].src));
      @(negedge clk);
      check(done == 1'b0, "R2 done single", W'(done), 0);
    end

    // Whole-vector model per code.
    for (int c = 0; c < 8; c++) begin
      int bad;
      bad = -1;
      pulse(3'(c), '1);
      for (int d = 0; d < N; d++)
        if (el(dst_new, d) != src_val(model_src(d, 3'(c)))) bad = d;
      check(bad < 0, "R3 full vector", (bad < 0) ? 8'h0 : el(dst_new, bad),
            (bad < 0) ? 8'h0 : src_val(model_src(bad, 3'(c))));
    end

    // Mask merge.
    begin
      logic [N-1:0] m;
      int bad;
      m = 64'hF0F0_3C3C_A5A5_0001;
      bad = -1;
      pulse(3'b100, m);
      for (int d = 0; d < N; d++) begin
        logic [W-1:0] exp;
        exp = m[d] ? src_val(model_src(d, 3'b100)) : old_val(d);
        if (el(dst_new, d) != exp) bad = d;
      end
      check(bad < 0, "R8 masked merge", (bad < 0) ? 8'h0 : el(dst_new, bad), 8'h0);
      pulse(3'b110, '0);
      check(el(dst_new, 18) == old_val(18), "R8 all masked", el(dst_new, 18), old_val(18));
    end

    // Hold without start.
    held = dst_new;
    @(negedge clk);
    dir_code = 3'b111; mask = '1;
    for (int i = 0; i < N; i++) src_vec[i*W +: W] = W'(8'h55 + i);
    repeat (3) @(negedge clk);
    check(dst_new == held, "R9 hold", el(dst_new, 0), el(held, 0));
    check(done == 1'b0, "R2 idle done", W'(done), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule